// File: doc/BRIEF.md
# Flash Block-Erase Command Sequencer

This block watches the byte writes that arrive at a flash device's write port and recognises the six-write command that unlocks and starts a block erase. The first five writes are a fixed unlock and setup pattern at two special low-word addresses. The sixth write carries the erase-confirm byte, and its address selects the block to be erased. Only the low 16 address bits are compared against the special addresses. The bits above them may hold any value, so the command works wherever the device is mapped.

When the sixth write is accepted, the block raises a one-cycle erase-start pulse and latches the 3-bit block number taken from address bits [18:16]. With 64 KB blocks, that covers eight blocks of a 4 Mbit array. A busy flag then stays high for a programmable number of cycles, which stands in for the internal erase time. Writes that arrive while busy is high are dropped.

If a write breaks the pattern, the sequencer returns to idle. The one exception is a write that is itself a valid first step (AAh to low word 5555h): that write restarts the pattern at step one.

Top module: `erase_seq`

## Requirements
- R1: After reset, erase_start and busy are 0 and erase_block is 0.
- R2: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 50h@any, accepted in that order, raise erase_start for exactly one cycle. The pulse appears in the cycle after the clock edge that samples the sixth write. Bits [31:16] of each address are ignored during matching.
- R3: erase_block takes bits [18:16] of the sixth write's address, in the same cycle as the pulse, and holds that value until the next erase starts.
- R4: busy rises together with erase_start and stays high for exactly ERASE_CYCLES clock cycles.
- R5: A write sampled while busy is 1 is ignored. A full command sent during busy produces no pulse, and steps sent during busy do not count toward a later command.
- R6: A write that does not match the expected step returns the sequencer to idle. The command must then start again from step one.
- R7: A mismatching write that is AAh to low word 5555h counts as step one of a new command.
- R8: The low 16 address bits of the five unlock writes must match exactly. For example, 5556h in place of 5555h aborts the command.
- R9: Cycles with wr_en low between the writes of a command do not affect the progress of the command.
- R10: A sixth write whose data is not 50h does not start an erase and leaves erase_block unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe; one write per cycle while high |
| wr_addr | input | 32 | Write byte address |
| wr_data | input | 8 | Write data byte |
| erase_start | output | 1 | One-cycle pulse when an erase command completes |
| erase_block | output | 3 | Number of the block to erase, held between commands |
| busy | output | 1 | High during the internal erase window |

## Verification
Each write is sampled on a rising edge. The erase pulse, the new block number and the rise of busy are all due in the cycle that follows that edge. busy falls exactly ERASE_CYCLES cycles after it rose. The reference model in the bench advances on the same rising edge as the design, and its expected outputs are compared on the falling edge. This keeps every comparison half a cycle clear of the edge that updates the registers. Directed scenarios add pulse-count checks, taken only after the busy window has fully drained, to confirm that aborts, restarts and writes during busy had the intended effect.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    localparam int MATCH_W = 16;

    localparam logic [MATCH_W-1:0] UNLOCK_ADDR_A = 16'h5555;
    localparam logic [MATCH_W-1:0] UNLOCK_ADDR_B = 16'h2AAA;
    localparam logic [7:0] KEY_A       = 8'hAA;
    localparam logic [7:0] KEY_B       = 8'h55;
    localparam logic [7:0] KEY_SETUP   = 8'h80;
    localparam logic [7:0] KEY_CONFIRM = 8'h50;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_U1    = 3'd1,
        ST_U2    = 3'd2,
        ST_SETUP = 3'd3,
        ST_U4    = 3'd4,
        ST_U5    = 3'd5
    } step_e;

    typedef struct packed {
        logic key_a;
        logic key_b;
        logic key_setup;
        logic key_confirm;
    } match_t;

endpackage

// File: rtl/erase_seq_match.sv
module erase_seq_match
    import erase_seq_pkg::*;
(
    input  logic [MATCH_W-1:0] addr_lo,
    input  logic [7:0]         data,
    output match_t             hit
);
    logic at_a;
    logic at_b;

    always_comb begin
        at_a            = (addr_lo == UNLOCK_ADDR_A);
        at_b            = (addr_lo == UNLOCK_ADDR_B);
        hit.key_a       = at_a && (data == KEY_A);
        hit.key_b       = at_b && (data == KEY_B);
        hit.key_setup   = at_a && (data == KEY_SETUP);
        hit.key_confirm = (data == KEY_CONFIRM);
    end
endmodule

// File: rtl/erase_seq_fsm.sv
module erase_seq_fsm
    import erase_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   accept,
    input  match_t hit,
    output logic   fire
);
    typedef struct packed {
        step_e step;
    } fsm_t;

    fsm_t s_d, s_q;
    logic expect_ok;

    always_comb begin
        s_d  = s_q;
        fire = 1'b0;
        unique case (s_q.step)
            ST_IDLE:  expect_ok = hit.key_a;
            ST_U1:    expect_ok = hit.key_b;
            ST_U2:    expect_ok = hit.key_setup;
            ST_SETUP: expect_ok = hit.key_a;
            ST_U4:    expect_ok = hit.key_b;
            ST_U5:    expect_ok = hit.key_confirm;
            default:  expect_ok = 1'b0;
        endcase
        if (accept) begin
            if (expect_ok) begin
                if (s_q.step == ST_U5) begin
                    fire       = 1'b1;
                    s_d.step   = ST_IDLE;
                end else begin
                    s_d.step   = step_e'(s_q.step + 3'd1);
                end
            end else if (hit.key_a) begin
                s_d.step = ST_U1;
            end else begin
                s_d.step = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{step: ST_IDLE};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/erase_seq_timer.sv
module erase_seq_timer #(
    parameter int ERASE_CYCLES = 50000,
    localparam int CNT_W = $clog2(ERASE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load) begin
            t_d.busy = 1'b1;
            t_d.cnt  = CNT_W'(ERASE_CYCLES - 1);
        end else if (t_q.busy) begin
            if (t_q.cnt == '0) t_d.busy = 1'b0;
            else               t_d.cnt  = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '{busy: 1'b0, cnt: '0};
        else        t_q <= t_d;
    end

    assign busy = t_q.busy;
endmodule

// File: rtl/erase_seq.sv
module erase_seq
    import erase_seq_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int BLK_LSB      = 16,
    parameter int BLK_W        = 3,
    parameter int ERASE_CYCLES = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              erase_start,
    output logic [BLK_W-1:0]  erase_block,
    output logic              busy
);
    localparam int BLK_MSB = BLK_LSB + BLK_W - 1;

    typedef struct packed {
        logic             start;
        logic [BLK_W-1:0] blk;
    } out_t;

    out_t   o_d, o_q;
    match_t hit;
    logic   accept;
    logic   fire;
    logic   unused_addr_hi;

    assign unused_addr_hi = ^wr_addr[ADDR_W-1:BLK_MSB+1];
    assign accept = wr_en && !busy;

    erase_seq_match u_match (
        .addr_lo (wr_addr[MATCH_W-1:0]),
        .data    (wr_data),
        .hit     (hit)
    );

    erase_seq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .hit    (hit),
        .fire   (fire)
    );

    erase_seq_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (fire),
        .busy  (busy)
    );

    always_comb begin
        o_d       = o_q;
        o_d.start = fire;
        if (fire) o_d.blk = wr_addr[BLK_MSB:BLK_LSB];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '{start: 1'b0, blk: '0};
        else        o_q <= o_d;
    end

    assign erase_start = o_q.start;
    assign erase_block = o_q.blk;
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
    parameter int BLK_W        = 3,
    parameter int ERASE_CYCLES = 50000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             erase_start,
    input logic [BLK_W-1:0] erase_block,
    input logic             busy
);
    logic [31:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 32'd1;
        else           run_q <= '0;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);                                   // R2
    AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> $past(wr_en));                                   // R2
    AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !erase_start |-> $stable(erase_block));                          // R3
    AST_BUSY_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> busy);                                           // R4
    AST_BUSY_LENGTH_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < 32'(ERASE_CYCLES)));                           // R4
    AST_BUSY_LENGTH_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == 32'(ERASE_CYCLES)));                   // R4
    AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> !$past(busy));                                   // R5
endmodule

bind erase_seq erase_seq_chk #(.BLK_W(BLK_W), .ERASE_CYCLES(ERASE_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .erase_start (erase_start),
    .erase_block (erase_block),
    .busy        (busy)
);

// File: tb/erase_seq_test.sv
module erase_seq_test;
    localparam int ERASE = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        erase_start;
    logic [2:0]  erase_block;
    logic        busy;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    bit done = 0;

    always #4 clk = ~clk;

    erase_seq #(.ERASE_CYCLES(ERASE)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .erase_start(erase_start),
        .erase_block(erase_block), .busy(busy)
    );

    // Behavioural reference model
    logic [15:0] pat_addr[$] = '{16'h5555, 16'h2AAA, 16'h5555, 16'h5555, 16'h2AAA};
    logic [7:0]  pat_data[$] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55};
    int   m_step = 0;
    int   m_cnt = 0;
    bit   m_busy = 0;
    bit   m_start = 0;
    logic [2:0] m_blk = '0;

    always @(posedge clk) begin
        bit was_busy;
        if (!rst_n) begin
            m_step = 0; m_cnt = 0; m_busy = 0; m_start = 0; m_blk = '0;
        end else begin
            was_busy = m_busy;
            m_start = 0;
            if (m_busy) begin
                if (m_cnt == 0) m_busy = 0;
                else m_cnt = m_cnt - 1;
            end
            if (wr_en && !was_busy) begin
                if (m_step == 5 && wr_data == 8'h50) begin
                    m_start = 1; m_busy = 1; m_cnt = ERASE - 1;
                    m_blk = wr_addr[18:16]; m_step = 0;
                end else if (m_step < 5 && wr_addr[15:0] == pat_addr[m_step]
                             && wr_data == pat_data[m_step]) begin
                    m_step = m_step + 1;
                end else if (wr_addr[15:0] == 16'h5555 && wr_data == 8'hAA) begin
                    m_step = 1;
                end else begin
                    m_step = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (erase_start !== m_start) begin
                fails++;
                $display("FAIL R2 erase_start=%0b expected %0b at %0t", erase_start, m_start, $time);
            end
            if (busy !== m_busy) begin
                fails++;
                $display("FAIL R4 busy=%0b expected %0b at %0t", busy, m_busy, $time);
            end
            if (erase_block !== m_blk) begin
                fails++;
                $display("FAIL R3 erase_block=%0d expected %0d at %0t", erase_block, m_blk, $time);
            end
            if (erase_start === 1'b1) pulses++;
        end
    end

    task automatic report();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic [15:0] hi, input logic [2:0] blk,
                       input logic [7:0] last, input int gap);
        wr({hi, 16'h5555}, 8'hAA); idle(gap);
        wr({hi, 16'h2AAA}, 8'h55); idle(gap);
        wr({hi, 16'h5555}, 8'h80); idle(gap);
        wr({hi, 16'h5555}, 8'hAA); idle(gap);
        wr({hi, 16'h2AAA}, 8'h55); idle(gap);
        wr({hi[15:3], blk, 16'h0C3F}, last);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (all requirements)");
        report();
    end

    initial begin
        int p0;
        idle(3);
        check_val("R1 erase_start in reset", int'(erase_start), 0);
        check_val("R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        idle(2);
        check_val("R1 erase_block after reset", int'(erase_block), 0);

        // R2/R3/R4: full command, arbitrary upper bits
        p0 = pulses;
        cmd(16'hFFB7, 3'd5, 8'h50, 0);
        idle(ERASE + 4);
        check_val("R2 one pulse", pulses - p0, 1);
        check_val("R3 block number", int'(erase_block), 5);

        // R5: full command during busy, and partial during busy
        p0 = pulses;
        cmd(16'h0001, 3'd2, 8'h50, 0);
        cmd(16'h0002, 3'd6, 8'h50, 0);
        idle(4);
        wr(32'h0000_5555, 8'hAA); wr(32'h0000_2AAA, 8'h55); wr(32'h0000_5555, 8'h80);
        idle(ERASE);
        wr(32'h0000_5555, 8'hAA); wr(32'h0000_2AAA, 8'h55); wr(32'h0003_0000, 8'h50);
        idle(ERASE + 4);
        check_val("R5 writes during busy ignored", pulses - p0, 1);
        check_val("R5 block from first command", int'(erase_block), 2);

        // R6: abort then resume mid-pattern
        p0 = pulses;
        wr(32'h0000_5555, 8'hAA); wr(32'h0000_2AAA, 8'h55); wr(32'h0000_5555, 8'h81);
        wr(32'h0000_5555, 8'hAA); wr(32'h0000_2AAA, 8'h55); wr(32'h0001_0000, 8'h50);
        idle(4);
        check_val("R6 abort returns to idle", pulses - p0, 0);

        // R7: restart on AA@5555 at step 2 and at step 5
        p0 = pulses;
        wr(32'h0000_5555, 8'hAA);
        cmd(16'h1234, 3'd3, 8'h50, 0);
        idle(ERASE + 4);
        check_val("R7 restart at step 2", pulses - p0, 1);
        p0 = pulses;
        wr(32'h0000_5555, 8'hAA); wr(32'h0000_2AAA, 8'h55);
        wr(32'h0000_5555, 8'h80); wr(32'h0000_5555, 8'hAA);
        cmd(16'h0000, 3'd7, 8'h50, 0);
        idle(ERASE + 4);
        check_val("R7 restart at step 5", pulses - p0, 1);
        check_val("R7 block", int'(erase_block), 7);

        // R8: near-miss low address
        p0 = pulses;
        wr(32'h0000_5556, 8'hAA); wr(32'h0000_2AAA, 8'h55); wr(32'h0000_5555, 8'h80);
        wr(32'h0000_5555, 8'hAA); wr(32'h0000_2AAA, 8'h55); wr(32'h0004_0000, 8'h50);
        idle(4);
        check_val("R8 low-word mismatch aborts", pulses - p0, 0);

        // R10: wrong confirm byte
        p0 = pulses;
        cmd(16'h0000, 3'd1, 8'h30, 0);
        idle(4);
        check_val("R10 no erase on bad confirm", pulses - p0, 0);
        check_val("R10 block unchanged", int'(erase_block), 7);

        // R9: idle gaps between writes
        p0 = pulses;
        cmd(16'hA5A0, 3'd4, 8'h50, 3);
        idle(ERASE + 4);
        check_val("R9 gaps tolerated", pulses - p0, 1);
        check_val("R9 block", int'(erase_block), 4);

        report();
    end
endmodule